// File: doc/BRIEF.md
# Flash Control Key-Unlock Guard

This block sits on a simple register bus in front of a flash program/erase engine. It holds the control word that the engine obeys and keeps it behind three lock bits. One lock guards the whole control word, one guards program-memory operations and one guards option-memory operations. All three are set out of reset. Software clears a lock only by writing a fixed pair of 32-bit keys, in order, to the key register for that lock. The program and option locks can only be opened once the main lock is open. Software can set any lock again at any time through the control register.

The block also keeps a status register for the engine's progress. Busy follows the engine's busy level. An end-of-operation flag and four error flags are set by pulses from the engine and stay set until software clears them by writing 1 to them.

A key sequencer that sees a wrong key, or a key out of order, freezes. After that its lock cannot be opened until reset. Reads are combinational from the current address.

Top module: `flk_guard`

## Requirements
- R1: After reset, all three lock bits read 1 at control offset 0 (bit 0 main, bit 1 program, bit 2 option). Program-enable, erase and fast-program read 0, and the status register (offset 1) reads 0.
- R2: Writing 0x89ABCDEF and then 0x02030405 to the main key register (offset 2) clears the main lock at the clock edge of the second write.
- R3: Writing 0x8C9DAEBF and then 0x13141516 to the program key register (offset 3) clears the program lock, but only while the main lock is clear. Writes to offset 3 while the main lock is set are ignored.
- R4: Writing 0xFBEAD9C8 and then 0x24252627 to the option key register (offset 4) clears the option lock, but only while the main lock is clear. Writes to offset 4 while the main lock is set are ignored.
- R5: While its lock is set and the key register is open to it, a wrong first key, or a wrong second key, freezes that lock's sequencer until reset. A later correct pair then leaves the lock set. The other locks are not affected.
- R6: A control write sets every lock bit whose data bit [2:0] is 1. A 0 in those bits never clears a lock, and writing 0x7 sets all three.
- R7: Control bits 3 (program enable), 9 (erase) and 10 (fast program) take the written value only if the main and program locks were both clear before the write. Otherwise they keep their value. They drive ctl_prog, ctl_erase and ctl_fast.
- R8: Status bit 0 shows eng_busy as it was one cycle earlier.
- R9: A pulse on eng_done sets status bit 3. Writing 1 to bit 3 clears it, and a pulse in the same cycle as the clear wins.
- R10: A pulse on eng_err[i] sets status bit 8+i. Writing 1 to that bit clears it, and a new pulse in the same cycle wins. Writing 0 leaves it unchanged.
- R11: Key registers and offsets 5 to 7 read 0, and lock_state mirrors control bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_busy | input | 1 | Engine busy level |
| eng_done | input | 1 | Engine end-of-operation pulse |
| eng_err | input | 4 | Engine error pulses |
| ctl_prog | output | 1 | Program-enable bit to engine |
| ctl_erase | output | 1 | Erase bit to engine |
| ctl_fast | output | 1 | Fast (half-page) program bit to engine |
| lock_state | output | 3 | Current lock bits {option, program, main} |

## Verification
The bench first writes program and option keys while the main lock is still set. A design that does not gate on the main lock would open those locks early. It writes the enable bits with only the main lock open, where a design that checks only one lock would let them through. It sends the keys in reverse order and sends a bad second key, then a correct pair. A sequencer that recovers instead of freezing would unlock. It also clears a status bit in the same cycle that the engine sets it, where a design with the wrong priority loses the event.

// File: rtl/flk_pkg.sv
package flk_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 3;
    localparam int N_LOCK  = 3;
    localparam int N_ERR   = 4;

    // register word offsets
    localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT     = 3'd1;
    localparam int                ADDR_KEY_BASE = 2;

    // control bit positions
    localparam int CTL_PROG_BIT  = 3;
    localparam int CTL_ERASE_BIT = 9;
    localparam int CTL_FAST_BIT  = 10;

    // status bit positions
    localparam int ST_BUSY_BIT = 0;
    localparam int ST_EOP_BIT  = 3;
    localparam int ST_ERR_LSB  = 8;

    localparam int MAIN_IDX = 0;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ARMED  = 2'd1,
        SEQ_FROZEN = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic fast;
        logic erase;
        logic prog;
    } op_bits_t;

    typedef struct packed {
        logic             busy;
        logic             eop;
        logic [N_ERR-1:0] err;
    } stat_t;

    function automatic word_t key_first(input int idx);
        case (idx)
            0:       return 32'h89AB_CDEF;
            1:       return 32'h8C9D_AEBF;
            default: return 32'hFBEA_D9C8;
        endcase
    endfunction

    function automatic word_t key_second(input int idx);
        case (idx)
            0:       return 32'h0203_0405;
            1:       return 32'h1314_1516;
            default: return 32'h2425_2627;
        endcase
    endfunction

    function automatic word_t pack_ctrl(input logic [N_LOCK-1:0] lk, input op_bits_t op);
        word_t w;
        w = '0;
        w[N_LOCK-1:0]    = lk;
        w[CTL_PROG_BIT]  = op.prog;
        w[CTL_ERASE_BIT] = op.erase;
        w[CTL_FAST_BIT]  = op.fast;
        return w;
    endfunction

    function automatic word_t pack_stat(input stat_t s);
        word_t w;
        w = '0;
        w[ST_BUSY_BIT] = s.busy;
        w[ST_EOP_BIT]  = s.eop;
        w[ST_ERR_LSB +: N_ERR] = s.err;
        return w;
    endfunction

endpackage

// File: rtl/flk_key_seq.sv
module flk_key_seq
    import flk_pkg::*;
#(
    parameter word_t KEY_A = '0,
    parameter word_t KEY_B = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  word_t wr_data,
    input  logic  allow,
    output logic  unlock
);

    seq_st_e st_q;
    logic    take;

    assign take   = wr_stb && allow;
    assign unlock = take && (st_q == SEQ_ARMED) && (wr_data == KEY_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEQ_IDLE;
        end else if (take) begin
            case (st_q)
                SEQ_IDLE:  st_q <= (wr_data == KEY_A) ? SEQ_ARMED : SEQ_FROZEN;
                SEQ_ARMED: st_q <= (wr_data == KEY_B) ? SEQ_IDLE  : SEQ_FROZEN;
                default:   st_q <= SEQ_FROZEN;
            endcase
        end
    end

endmodule

// File: rtl/flk_ctrl_reg.sv
module flk_ctrl_reg
    import flk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [N_LOCK-1:0] wr_lock_set,
    input  op_bits_t          wr_op,
    input  logic [N_LOCK-1:0] unlock,
    output logic [N_LOCK-1:0] lock_q,
    output op_bits_t          op_q
);

    logic [N_LOCK-1:0] set_mask;
    logic              op_open;

    assign set_mask = wr_stb ? wr_lock_set : '0;
    assign op_open  = !lock_q[MAIN_IDX] && !lock_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= '1;
            op_q   <= '0;
        end else begin
            lock_q <= (lock_q & ~unlock) | set_mask;
            if (wr_stb && op_open)
                op_q <= wr_op;
        end
    end

endmodule

// File: rtl/flk_stat_reg.sv
module flk_stat_reg
    import flk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic             wr_eop_clr,
    input  logic [N_ERR-1:0] wr_err_clr,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic [N_ERR-1:0] eng_err,
    output stat_t            stat_q
);

    logic [N_ERR-1:0] err_clr;
    logic             eop_clr;

    assign err_clr = wr_stb ? wr_err_clr : '0;
    assign eop_clr = wr_stb && wr_eop_clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.busy <= eng_busy;
            stat_q.eop  <= eng_done | (stat_q.eop & ~eop_clr);
            stat_q.err  <= eng_err  | (stat_q.err & ~err_clr);
        end
    end

endmodule

// File: rtl/flk_guard.sv
module flk_guard
    import flk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [N_ERR-1:0]  eng_err,
    output logic              ctl_prog,
    output logic              ctl_erase,
    output logic              ctl_fast,
    output logic [N_LOCK-1:0] lock_state
);

    logic              wr;
    logic              ctrl_wr;
    logic              stat_wr;
    logic [N_LOCK-1:0] key_wr;
    logic [N_LOCK-1:0] allow;
    logic [N_LOCK-1:0] unlock;
    logic [N_LOCK-1:0] lock_q;
    op_bits_t          op_q;
    op_bits_t          wr_op;
    stat_t             stat_q;
    logic [N_ERR-1:0]  err_q;

    assign wr      = bus_sel && bus_we;
    assign ctrl_wr = wr && (bus_addr == ADDR_CTRL);
    assign stat_wr = wr && (bus_addr == ADDR_STAT);

    generate
        for (genvar g = 0; g < N_LOCK; g++) begin : g_lock
            assign key_wr[g] = wr && (bus_addr == ADDR_W'(ADDR_KEY_BASE + g));
            if (g == MAIN_IDX) begin : g_main
                assign allow[g] = lock_q[g];
            end else begin : g_sub
                assign allow[g] = lock_q[g] && !lock_q[MAIN_IDX];
            end
            flk_key_seq #(
                .KEY_A (key_first(g)),
                .KEY_B (key_second(g))
            ) u_seq (
                .clk     (clk),
                .rst     (rst),
                .wr_stb  (key_wr[g]),
                .wr_data (bus_wdata),
                .allow   (allow[g]),
                .unlock  (unlock[g])
            );
        end
    endgenerate

    assign wr_op.prog  = bus_wdata[CTL_PROG_BIT];
    assign wr_op.erase = bus_wdata[CTL_ERASE_BIT];
    assign wr_op.fast  = bus_wdata[CTL_FAST_BIT];

    flk_ctrl_reg u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (ctrl_wr),
        .wr_lock_set (bus_wdata[N_LOCK-1:0]),
        .wr_op       (wr_op),
        .unlock      (unlock),
        .lock_q      (lock_q),
        .op_q        (op_q)
    );

    flk_stat_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (stat_wr),
        .wr_eop_clr (bus_wdata[ST_EOP_BIT]),
        .wr_err_clr (bus_wdata[ST_ERR_LSB +: N_ERR]),
        .eng_busy   (eng_busy),
        .eng_done   (eng_done),
        .eng_err    (eng_err),
        .stat_q     (stat_q)
    );

    assign err_q = stat_q.err;

    always_comb begin
        if (bus_addr == ADDR_CTRL)
            bus_rdata = pack_ctrl(lock_q, op_q);
        else if (bus_addr == ADDR_STAT)
            bus_rdata = pack_stat(stat_q);
        else
            bus_rdata = '0;
    end

    assign ctl_prog   = op_q.prog;
    assign ctl_erase  = op_q.erase;
    assign ctl_fast   = op_q.fast;
    assign lock_state = lock_q;

endmodule

// File: rtl/flk_guard_chk.sv
module flk_guard_chk
    import flk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              eng_busy,
    input logic              busy_bit,
    input logic [N_ERR-1:0]  err_bits,
    input logic              ctl_prog,
    input logic              ctl_erase,
    input logic              ctl_fast,
    input logic [N_LOCK-1:0] lock_state
);

    logic key_wr;
    logic stat_wr;
    assign key_wr  = bus_sel && bus_we && (bus_addr >= 3'd2) && (bus_addr <= 3'd4);
    assign stat_wr = bus_sel && bus_we && (bus_addr == ADDR_STAT);

    // R1: all locks set on leaving reset
    a_r1_reset_locked: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (lock_state == 3'b111));

    // R6: a lock only drops the cycle after a key register write
    a_r6_no_direct_clear: assert property (@(posedge clk) disable iff (rst)
        (|($past(lock_state) & ~lock_state)) |-> $past(key_wr));

    // R3: program lock only opens with main lock already open
    a_r3_prog_after_main: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_state[1]) |-> !$past(lock_state[0]));

    // R4: option lock only opens with main lock already open
    a_r4_opt_after_main: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_state[2]) |-> !$past(lock_state[0]));

    // R7: operation bits move only when both gating locks were open
    a_r7_gated_ops: assert property (@(posedge clk) disable iff (rst)
        !$stable({ctl_prog, ctl_erase, ctl_fast}) |-> ($past(lock_state[1:0]) == 2'b00));

    // R8: busy follows engine one cycle later
    a_r8_busy_follow: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (busy_bit == $past(eng_busy)));

    // R10: error flags drop only after a status write
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (|($past(err_bits) & ~err_bits)) |-> $past(stat_wr));

endmodule

bind flk_guard flk_guard_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .eng_busy   (eng_busy),
    .busy_bit   (stat_q.busy),
    .err_bits   (err_q),
    .ctl_prog   (ctl_prog),
    .ctl_erase  (ctl_erase),
    .ctl_fast   (ctl_fast),
    .lock_state (lock_state)
);

// File: tb/tb_flk_guard.sv
`timescale 1ns/1ps
module tb_flk_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        eng_busy = 1'b0;
    logic        eng_done = 1'b0;
    logic [3:0]  eng_err = 4'd0;
    logic        ctl_prog, ctl_erase, ctl_fast;
    logic [2:0]  lock_state;

    always #2 clk = ~clk;

    flk_guard dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .ctl_prog(ctl_prog), .ctl_erase(ctl_erase), .ctl_fast(ctl_fast),
        .lock_state(lock_state)
    );

    int    checks = 0;
    int    failures = 0;
    bit    finished = 0;
    string cur_req = "R1";

    // reference model state
    bit       m_lock [3];
    int       m_seq  [3];   // 0 idle, 1 got first key, 2 frozen
    bit       m_pe, m_er, m_fp, m_busy, m_eop;
    bit [3:0] m_err;

    function automatic logic [31:0] k1(int i);
        return (i == 0) ? 32'h89ABCDEF : (i == 1) ? 32'h8C9DAEBF : 32'hFBEAD9C8;
    endfunction
    function automatic logic [31:0] k2(int i);
        return (i == 0) ? 32'h02030405 : (i == 1) ? 32'h13141516 : 32'h24252627;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 3; i++) begin m_lock[i] = 1; m_seq[i] = 0; end
        m_pe = 0; m_er = 0; m_fp = 0; m_busy = 0; m_eop = 0; m_err = 0;
    endtask

    task automatic model_step();
        bit unl [3];
        bit w;
        bit n_lock [3];
        if (rst) begin model_reset(); return; end
        w = bus_sel && bus_we;
        for (int i = 0; i < 3; i++) begin
            bit ok;
            unl[i] = 0;
            ok = m_lock[i] && (i == 0 || !m_lock[0]);
            if (w && bus_addr == 3'(2 + i) && ok) begin
                if (m_seq[i] == 0)      m_seq[i] = (bus_wdata == k1(i)) ? 1 : 2;
                else if (m_seq[i] == 1) begin
                    if (bus_wdata == k2(i)) begin unl[i] = 1; m_seq[i] = 0; end
                    else m_seq[i] = 2;
                end
            end
        end
        for (int i = 0; i < 3; i++)
            n_lock[i] = (m_lock[i] && !unl[i]) || (w && bus_addr == 3'd0 && bus_wdata[i]);
        if (w && bus_addr == 3'd0 && !m_lock[0] && !m_lock[1]) begin
            m_pe = bus_wdata[3]; m_er = bus_wdata[9]; m_fp = bus_wdata[10];
        end
        for (int i = 0; i < 3; i++) m_lock[i] = n_lock[i];
        m_busy = eng_busy;
        m_eop  = eng_done || (m_eop && !(w && bus_addr == 3'd1 && bus_wdata[3]));
        m_err  = eng_err | (m_err & ~((w && bus_addr == 3'd1) ? bus_wdata[11:8] : 4'd0));
    endtask

    function automatic logic [31:0] exp_read(logic [2:0] a);
        logic [31:0] v = 0;
        if (a == 3'd0) begin
            v[0] = m_lock[0]; v[1] = m_lock[1]; v[2] = m_lock[2];
            v[3] = m_pe; v[9] = m_er; v[10] = m_fp;
        end else if (a == 3'd1) begin
            v[0] = m_busy; v[3] = m_eop; v[11:8] = m_err;
        end
        return v;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(cur_req, "rdata", bus_rdata, exp_read(bus_addr));
        chk(cur_req, "lock_state", {29'd0, lock_state}, {29'd0, m_lock[2], m_lock[1], m_lock[0]});
        chk(cur_req, "ctl", {29'd0, ctl_fast, ctl_erase, ctl_prog}, {29'd0, m_fp, m_er, m_pe});
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(logic [2:0] a);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        tick();
        bus_sel = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        // R1: reset state
        cur_req = "R1";
        do_reset();
        rd(3'd0); chk("R1", "ctrl after reset", bus_rdata, 32'h7);
        rd(3'd1); chk("R1", "status after reset", bus_rdata, 32'h0);

        // R6: zeros never clear locks
        cur_req = "R6";
        wr(3'd0, 32'h0); rd(3'd0); chk("R6", "zero write keeps locks", bus_rdata, 32'h7);

        // R3/R4: sub keys ignored while main locked
        cur_req = "R3";
        wr(3'd3, k1(1)); wr(3'd3, k2(1));
        cur_req = "R4";
        wr(3'd4, k1(2)); wr(3'd4, k2(2));
        chk("R4", "sub keys ignored", {29'd0, lock_state}, 32'h7);

        // R2: main unlock
        cur_req = "R2";
        wr(3'd2, k1(0)); chk("R2", "first key alone", {29'd0, lock_state}, 32'h7);
        wr(3'd2, k2(0)); chk("R2", "main opened", {29'd0, lock_state}, 32'h6);

        // R7: op bits blocked while program lock set
        cur_req = "R7";
        wr(3'd0, 32'h608); rd(3'd0); chk("R7", "ops blocked", bus_rdata, 32'h6);

        // R3: program unlock now works
        cur_req = "R3";
        wr(3'd3, k1(1)); wr(3'd3, k2(1));
        chk("R3", "program opened", {29'd0, lock_state}, 32'h4);

        // R7: op bits accepted
        cur_req = "R7";
        wr(3'd0, 32'h608); rd(3'd0); chk("R7", "ops written", bus_rdata, 32'h60C);
        chk("R7", "ctl pins", {29'd0, ctl_fast, ctl_erase, ctl_prog}, 32'h7);
        wr(3'd0, 32'h200); rd(3'd0); chk("R7", "erase only", bus_rdata, 32'h204);

        // R6: relock all with 0x7, ops cleared by same write
        cur_req = "R6";
        wr(3'd0, 32'h7); rd(3'd0); chk("R6", "relock all", bus_rdata, 32'h7);
        wr(3'd0, 32'h608); rd(3'd0); chk("R6", "relocked blocks ops", bus_rdata, 32'h7);

        // R2: unlock again after relock
        cur_req = "R2";
        wr(3'd2, k1(0)); wr(3'd2, k2(0));
        chk("R2", "main reopened", {29'd0, lock_state}, 32'h6);

        // R5: option sequencer frozen by a bad first key
        cur_req = "R5";
        wr(3'd4, 32'h12345678); wr(3'd4, k1(2)); wr(3'd4, k2(2));
        chk("R5", "option stays locked", {29'd0, lock_state}, 32'h6);
        wr(3'd3, k1(1)); wr(3'd3, k2(1));
        chk("R5", "program unaffected", {29'd0, lock_state}, 32'h4);

        // R5: main frozen by reversed keys
        wr(3'd0, 32'h1);
        wr(3'd2, k2(0)); wr(3'd2, k1(0)); wr(3'd2, k2(0));
        chk("R5", "main frozen", {29'd0, lock_state}, 32'h5);

        // R5/R4: after reset, bad second key freezes main, then fresh option unlock
        do_reset();
        cur_req = "R5";
        wr(3'd2, k1(0)); wr(3'd2, 32'h0); wr(3'd2, k1(0)); wr(3'd2, k2(0));
        chk("R5", "bad second key freezes", {29'd0, lock_state}, 32'h7);
        do_reset();
        cur_req = "R4";
        wr(3'd2, k1(0)); rd(3'd1); wr(3'd2, k2(0));
        wr(3'd4, k1(2)); wr(3'd4, k2(2));
        chk("R4", "option opened", {29'd0, lock_state}, 32'h2);
        wr(3'd0, 32'h608); rd(3'd0); chk("R4", "ops still gated by program lock", bus_rdata, 32'h2);

        // R8: busy follows
        cur_req = "R8";
        bus_addr = 3'd1;
        eng_busy = 1; tick(); chk("R8", "busy set", bus_rdata, 32'h1);
        eng_busy = 0; tick(); chk("R8", "busy clear", bus_rdata, 32'h0);
        for (int i = 0; i < 6; i++) begin eng_busy = i[0]; tick(); end
        eng_busy = 0;

        // R9: end of operation
        cur_req = "R9";
        eng_done = 1; tick(); eng_done = 0; tick();
        chk("R9", "eop set", bus_rdata, 32'h8);
        wr(3'd1, 32'h0); chk("R9", "zero keeps eop", bus_rdata, 32'h8);
        eng_done = 1; wr(3'd1, 32'h8); eng_done = 0;
        chk("R9", "set wins over clear", bus_rdata, 32'h8);
        wr(3'd1, 32'h8); chk("R9", "eop cleared", bus_rdata, 32'h0);

        // R10: error flags
        cur_req = "R10";
        eng_err = 4'h5; tick(); eng_err = 4'h0; tick();
        chk("R10", "errors set", bus_rdata, 32'h500);
        wr(3'd1, 32'h100); chk("R10", "clear bit 8 only", bus_rdata, 32'h400);
        eng_err = 4'h4; wr(3'd1, 32'hF00); eng_err = 4'h0;
        chk("R10", "set wins", bus_rdata, 32'h400);
        eng_err = 4'hA; tick(); eng_err = 4'h0;
        wr(3'd1, 32'hF00); chk("R10", "all cleared", bus_rdata, 32'h0);

        // R11: key and unused offsets read zero
        cur_req = "R11";
        for (int a = 2; a < 8; a++) begin
            rd(3'(a)); chk("R11", "zero readback", bus_rdata, 32'h0);
        end
        rd(3'd0); chk("R11", "lock mirror", {29'd0, lock_state}, {29'd0, bus_rdata[2:0]});

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule